// File: doc/BRIEF.md
# One-Wire ROM Search Accelerator

This block walks the ROM-search tree of a one-wire bus on its own, one identifier position at a time. For every position it runs a triplet of bus slots. The first slot reads the true bit and the second reads its complement. The third writes the branch it has chosen. The host turns the mode on with a plain enable pin. It does so only after it has reset the bus and sent the search command byte in normal mode. From then on it feeds the block one byte per group of four positions. Each byte it sends carries four direction hints. The block answers each byte with one result byte that packs the four chosen bits and four discrepancy flags. Sixteen exchanges cover a 64-bit identifier. Nibble i of the identifier, taken from the chosen bits of exchange i, fills identifier bits 4i to 4i+3, so the least significant nibble comes first.

Host bytes enter through a valid/ready port and results leave through another. The input is ready only while the mode is enabled, no byte is being worked on, and no result is waiting. So the host stalls the bus simply by not taking a result. A result stays on the output, unchanged, until the host takes it. The bus side is a single open-drain pull-low output plus the sensed line level. Slot timing is counted in clock cycles. A second set of timing parameters, chosen by the overdrive pin, gives the faster bus speed.

Top module: `ow_srch_accel`

## Requirements
- R1: After reset, out_valid and ow_pull are 0. With srch_en low, in_ready is 0.
- R2: While srch_en is 0, in_ready is 0 and ow_pull stays 0. Clearing srch_en stops any byte in progress and drops any pending result, so one cycle later ow_pull and out_valid are both 0.
- R3: in_ready is 1 only when srch_en is 1, no byte is in progress and out_valid is 0. A byte is taken when in_valid and in_ready are both 1, and in_ready is then 0 on the next cycle. While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R4: Each accepted byte makes exactly 12 bus slots: 3 per position, for 4 positions in order k = 0..3. Position k of exchange i is identifier bit 4i+k, and its direction hint is in_data bit 2k+1.
- R5: In the result byte, bit 2k+1 is the chosen bit of position k and bit 2k is its discrepancy flag. Over a full search with a single device present, the chosen bits rebuild that device's identifier and every discrepancy flag is 0.
- R6: When the true and complement reads differ, the chosen bit equals the true read, the discrepancy flag is 0 and that bit is written.
- R7: When both reads are 0, the discrepancy flag is 1 and the host's direction hint is chosen and written. With all hints at 0 (or all at 1), the search follows the 0 (or 1) branch and finds a device that is present.
- R8: When both reads are 1, the discrepancy flag is 1, the chosen bit is 1 and a 1 is written. With no device present, every result byte is 0xFF.
- R9: out_valid rises only after the recovery of the 12th slot of a byte. While out_valid is 1, ow_pull is 0.
- R10: Read slots and write-1 slots pull the line low for LOW1 cycles, and write-0 slots for LOW0 cycles. The normal or overdrive set is chosen by the overdrive pin, sampled at the start of each slot.
- R11: A read slot takes the line level in the slot cycle SAMPLE, counted from the first low cycle as cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_en | input | 1 | Search mode enable; low aborts and idles |
| overdrive | input | 1 | Selects the overdrive timing set for the next slots |
| in_valid | input | 1 | Host direction byte is valid |
| in_ready | output | 1 | Block accepts a direction byte |
| in_data | input | 8 | Direction hints at bits 1,3,5,7 |
| out_valid | output | 1 | Result byte is valid |
| out_ready | input | 1 | Host takes the result byte |
| out_data | output | 8 | Chosen bits at odd positions, discrepancy flags at even positions |
| ow_pull | output | 1 | 1 pulls the one-wire line low |
| ow_sense | input | 1 | Sensed one-wire line level |

## Verification
A bad decision in a triplet shows up at once as a wrong write-slot length on the line. Devices that should have stayed in the search drop out, so every later result byte of that search goes wrong, and the fault is visible as soon as the affected byte is returned. A miscounted slot or position sequencer moves the rise of out_valid away from the 12th slot. It also shifts the identifier nibbles, which breaks the rebuilt identifier within the first exchange. A wrong timing selection changes the measured low-pulse widths in the very first slot after the overdrive pin changes.

// File: rtl/ow_srch_pkg.sv
package ow_srch_pkg;

  localparam int POS_PER_BYTE = 4;
  localparam int SLOTS_PER_POS = 3;

  typedef enum logic [1:0] {
    SLOT_RD = 2'd0,
    SLOT_W0 = 2'd1,
    SLOT_W1 = 2'd2
  } slot_kind_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_ISSUE = 2'd1,
    ENG_WAIT  = 2'd2
  } eng_state_e;

endpackage

// File: rtl/ow_slot_timer.sv
module ow_slot_timer
  import ow_srch_pkg::*;
#(
  parameter int NRM_LOW1   = 6,
  parameter int NRM_LOW0   = 48,
  parameter int NRM_SAMPLE = 12,
  parameter int NRM_SLOT   = 60,
  parameter int NRM_REC    = 4,
  parameter int OVD_LOW1   = 2,
  parameter int OVD_LOW0   = 10,
  parameter int OVD_SAMPLE = 4,
  parameter int OVD_SLOT   = 16,
  parameter int OVD_REC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       start,
  input  slot_kind_e kind,
  input  logic       ovd,
  input  logic       sense,
  output logic       pull,
  output logic       rd_bit,
  output logic       done
);

  localparam int NRM_TOTAL = NRM_SLOT + NRM_REC;
  localparam int OVD_TOTAL = OVD_SLOT + OVD_REC;
  localparam int MAX_TOTAL = (NRM_TOTAL > OVD_TOTAL) ? NRM_TOTAL : OVD_TOTAL;
  localparam int CW        = $clog2(MAX_TOTAL + 1);

  localparam logic [CW-1:0] N_L1   = CW'(NRM_LOW1);
  localparam logic [CW-1:0] N_L0   = CW'(NRM_LOW0);
  localparam logic [CW-1:0] N_SMP  = CW'(NRM_SAMPLE);
  localparam logic [CW-1:0] N_LAST = CW'(NRM_TOTAL - 1);
  localparam logic [CW-1:0] O_L1   = CW'(OVD_LOW1);
  localparam logic [CW-1:0] O_L0   = CW'(OVD_LOW0);
  localparam logic [CW-1:0] O_SMP  = CW'(OVD_SAMPLE);
  localparam logic [CW-1:0] O_LAST = CW'(OVD_TOTAL - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  slot_kind_e    kind_q;
  logic          ovd_q;
  logic          bit_q;
  logic [CW-1:0] low_len;
  logic [CW-1:0] smp_at;
  logic [CW-1:0] last_at;

  always_comb begin
    if (ovd_q) begin
      low_len = (kind_q == SLOT_W0) ? O_L0 : O_L1;
      smp_at  = O_SMP;
      last_at = O_LAST;
    end else begin
      low_len = (kind_q == SLOT_W0) ? N_L0 : N_L1;
      smp_at  = N_SMP;
      last_at = N_LAST;
    end
  end

  assign pull   = busy_q && (cnt_q < low_len);
  assign done   = busy_q && (cnt_q == last_at);
  assign rd_bit = bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= SLOT_RD;
      ovd_q  <= 1'b0;
      bit_q  <= 1'b1;
    end else if (abort) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      kind_q <= kind;
      ovd_q  <= ovd;
    end else if (busy_q) begin
      if (cnt_q == smp_at) bit_q <= sense;
      if (done) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4: the sequencer never launches a slot over one still running
  assert_start_when_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R10: the line is released in the cycle after a slot finishes
  assert_release_after_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !pull);

endmodule

// File: rtl/ow_srch_engine.sv
module ow_srch_engine
  import ow_srch_pkg::*;
#(
  parameter int NPOS = POS_PER_BYTE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            go,
  input  logic [NPOS-1:0] dir,
  output logic            slot_start,
  output slot_kind_e      slot_kind,
  input  logic            slot_done,
  input  logic            slot_bit,
  output logic [NPOS-1:0] chosen,
  output logic [NPOS-1:0] disc,
  output logic            byte_done,
  output logic            idle
);

  localparam int PW = (NPOS > 1) ? $clog2(NPOS) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(NPOS - 1);

  eng_state_e      state_q;
  logic [PW-1:0]   pos_q;
  logic [1:0]      sub_q;
  logic            first_q;
  logic            wr_q;
  logic [NPOS-1:0] dir_q;
  logic [NPOS-1:0] chosen_q;
  logic [NPOS-1:0] disc_q;
  logic            pick_bit;
  logic            pick_flag;

  // triplet decision from the true read (first_q) and the complement read
  always_comb begin
    if (first_q != slot_bit) begin
      pick_bit  = first_q;
      pick_flag = 1'b0;
    end else if (!first_q) begin
      pick_bit  = dir_q[pos_q];
      pick_flag = 1'b1;
    end else begin
      pick_bit  = 1'b1;
      pick_flag = 1'b1;
    end
  end

  assign slot_start = (state_q == ENG_ISSUE);
  assign slot_kind  = (sub_q != 2'd2) ? SLOT_RD : (wr_q ? SLOT_W1 : SLOT_W0);
  assign byte_done  = (state_q == ENG_WAIT) && slot_done && (sub_q == 2'd2) && (pos_q == POS_LAST);
  assign idle       = (state_q == ENG_IDLE);
  assign chosen     = chosen_q;
  assign disc       = disc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ENG_IDLE;
      pos_q    <= '0;
      sub_q    <= 2'd0;
      first_q  <= 1'b1;
      wr_q     <= 1'b1;
      dir_q    <= '0;
      chosen_q <= '0;
      disc_q   <= '0;
    end else if (!en) begin
      state_q <= ENG_IDLE;
    end else begin
      case (state_q)
        ENG_IDLE: if (go) begin
          pos_q    <= '0;
          sub_q    <= 2'd0;
          dir_q    <= dir;
          chosen_q <= '0;
          disc_q   <= '0;
          state_q  <= ENG_ISSUE;
        end
        ENG_ISSUE: state_q <= ENG_WAIT;
        ENG_WAIT: if (slot_done) begin
          case (sub_q)
            2'd0: begin
              first_q <= slot_bit;
              sub_q   <= 2'd1;
              state_q <= ENG_ISSUE;
            end
            2'd1: begin
              chosen_q[pos_q] <= pick_bit;
              disc_q[pos_q]   <= pick_flag;
              wr_q            <= pick_bit;
              sub_q           <= 2'd2;
              state_q         <= ENG_ISSUE;
            end
            default: begin
              sub_q <= 2'd0;
              if (pos_q == POS_LAST) begin
                state_q <= ENG_IDLE;
              end else begin
                pos_q   <= pos_q + 1'b1;
                state_q <= ENG_ISSUE;
              end
            end
          endcase
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  // R4: a new byte is only started from idle
  assert_go_from_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && en) |-> idle);

endmodule

// File: rtl/ow_srch_pack.sv
module ow_srch_pack #(
  parameter int NPOS = 4
) (
  input  logic [2*NPOS-1:0] host_byte,
  input  logic [NPOS-1:0]   chosen,
  input  logic [NPOS-1:0]   disc,
  output logic [NPOS-1:0]   dir,
  output logic [2*NPOS-1:0] result
);

  for (genvar k = 0; k < NPOS; k++) begin : g_lane
    assign dir[k]        = host_byte[2*k+1];
    assign result[2*k+1] = chosen[k];
    assign result[2*k]   = disc[k];
  end

endmodule

// File: rtl/ow_srch_accel.sv
module ow_srch_accel
  import ow_srch_pkg::*;
#(
  parameter int NRM_LOW1   = 6,
  parameter int NRM_LOW0   = 48,
  parameter int NRM_SAMPLE = 12,
  parameter int NRM_SLOT   = 60,
  parameter int NRM_REC    = 4,
  parameter int OVD_LOW1   = 2,
  parameter int OVD_LOW0   = 10,
  parameter int OVD_SAMPLE = 4,
  parameter int OVD_SLOT   = 16,
  parameter int OVD_REC    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srch_en,
  input  logic       overdrive,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       ow_pull,
  input  logic       ow_sense
);

  localparam int NPOS = POS_PER_BYTE;

  logic            go;
  logic [NPOS-1:0] dir;
  logic [NPOS-1:0] chosen;
  logic [NPOS-1:0] disc;
  logic            slot_start;
  slot_kind_e      slot_kind;
  logic            slot_done;
  logic            slot_bit;
  logic            byte_done;
  logic            eng_idle;
  logic            res_valid_q;

  assign in_ready  = srch_en && eng_idle && !res_valid_q;
  assign go        = in_valid && in_ready;
  assign out_valid = res_valid_q;

  ow_srch_pack #(.NPOS(NPOS)) u_pack (
    .host_byte (in_data),
    .chosen    (chosen),
    .disc      (disc),
    .dir       (dir),
    .result    (out_data)
  );

  ow_srch_engine #(.NPOS(NPOS)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (srch_en),
    .go         (go),
    .dir        (dir),
    .slot_start (slot_start),
    .slot_kind  (slot_kind),
    .slot_done  (slot_done),
    .slot_bit   (slot_bit),
    .chosen     (chosen),
    .disc       (disc),
    .byte_done  (byte_done),
    .idle       (eng_idle)
  );

  ow_slot_timer #(
    .NRM_LOW1(NRM_LOW1), .NRM_LOW0(NRM_LOW0), .NRM_SAMPLE(NRM_SAMPLE),
    .NRM_SLOT(NRM_SLOT), .NRM_REC(NRM_REC),
    .OVD_LOW1(OVD_LOW1), .OVD_LOW0(OVD_LOW0), .OVD_SAMPLE(OVD_SAMPLE),
    .OVD_SLOT(OVD_SLOT), .OVD_REC(OVD_REC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .abort  (!srch_en),
    .start  (slot_start),
    .kind   (slot_kind),
    .ovd    (overdrive),
    .sense  (ow_sense),
    .pull   (ow_pull),
    .rd_bit (slot_bit),
    .done   (slot_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
    end else if (!srch_en) begin
      res_valid_q <= 1'b0;
    end else if (byte_done) begin
      res_valid_q <= 1'b1;
    end else if (out_ready) begin
      res_valid_q <= 1'b0;
    end
  end

  // R2: disabling releases the line and drops the pending result
  assert_disable_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> (!ow_pull && !out_valid));

  // R3: a result waiting on back-pressure is held unchanged
  assert_hold_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && srch_en) |=> (out_valid && $stable(out_data)));

  // R3: an accepted byte closes the input for the next cycle
  assert_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9: a finished result never coexists with bus activity
  assert_result_bus_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !ow_pull);

endmodule

// File: tb/test_ow_srch_accel.sv
module test_ow_srch_accel;

  localparam int NL1 = 6,  NL0 = 48, NSM = 12, NSL = 60, NRC = 4;
  localparam int OL1 = 2,  OL0 = 10, OSM = 4,  OSL = 16, ORC = 2;
  localparam int NDEV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srch_en = 1'b0;
  logic       overdrive = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       ow_pull;
  logic       ow_sense;

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;

  // device population on the bus
  logic [63:0] rom [NDEV];
  bit          present [NDEV];
  bit          dev_act [NDEV];
  int          dev_bit = 0;
  bit          dev_low = 1'b0;
  bit          pull_q = 1'b0;
  int          slot_c = 0;
  int          low_cnt = 0;
  int          cur_sub = 0;
  int          sub_nx = 0;
  int          slot_total = 0;
  int          max_low = 0;
  int          min_low = 1000;
  bit          use_ovd = 1'b0;

  // reference search state
  bit m_act [NDEV];
  int m_bit = 0;

  assign ow_sense = !ow_pull && !dev_low;

  ow_srch_accel #(
    .NRM_LOW1(NL1), .NRM_LOW0(NL0), .NRM_SAMPLE(NSM), .NRM_SLOT(NSL), .NRM_REC(NRC),
    .OVD_LOW1(OL1), .OVD_LOW0(OL0), .OVD_SAMPLE(OSM), .OVD_SLOT(OSL), .OVD_REC(ORC)
  ) i_ow_srch_accel (
    .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .overdrive(overdrive),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .ow_pull(ow_pull), .ow_sense(ow_sense)
  );

  // bus device model, evaluated away from the active edge
  always @(negedge clk) begin
    bit any;
    int smp;
    int thr;
    smp = use_ovd ? OSM : NSM;
    thr = use_ovd ? (OL1 + OL0) / 2 : (NL1 + NL0) / 2;
    if (ow_pull && !pull_q) begin
      slot_c = 0;
      low_cnt = 1;
      cur_sub = sub_nx;
      sub_nx = (sub_nx == 2) ? 0 : sub_nx + 1;
      slot_total++;
    end else begin
      slot_c++;
      if (ow_pull) low_cnt++;
    end
    if (!ow_pull && pull_q) begin
      if (low_cnt > max_low) max_low = low_cnt;
      if (low_cnt < min_low) min_low = low_cnt;
      if (cur_sub == 2 && dev_bit < 64) begin
        bit w;
        w = (low_cnt >= thr) ? 1'b0 : 1'b1;
        for (int d = 0; d < NDEV; d++)
          if (dev_act[d] && rom[d][dev_bit] != w) dev_act[d] = 1'b0;
        dev_bit++;
      end
    end
    any = 1'b0;
    if (cur_sub != 2 && slot_c <= smp + 2 && dev_bit < 64)
      for (int d = 0; d < NDEV; d++)
        if (dev_act[d] && (rom[d][dev_bit] == (cur_sub == 1))) any = 1'b1;
    dev_low = any;
    pull_q = ow_pull;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference result for one exchange, from the triplet rules
  task automatic model_byte(input logic [7:0] dir, output logic [7:0] res);
    res = 8'h00;
    for (int k = 0; k < 4; k++) begin
      bit any0, any1, a, b, ch, ds;
      any0 = 0; any1 = 0;
      for (int d = 0; d < NDEV; d++) if (m_act[d]) begin
        if (rom[d][m_bit]) any1 = 1; else any0 = 1;
      end
      a = !any0; b = !any1;
      if (a != b) begin ch = a; ds = 0; end
      else if (!a) begin ch = dir[2*k+1]; ds = 1; end
      else begin ch = 1; ds = 1; end
      for (int d = 0; d < NDEV; d++) if (m_act[d] && rom[d][m_bit] != ch) m_act[d] = 0;
      res[2*k+1] = ch;
      res[2*k] = ds;
      m_bit++;
    end
  endtask

  task automatic prepare(input bit ovd, input int ndev);
    srch_en = 1'b0;
    repeat (3) @(negedge clk);
    overdrive = ovd;
    use_ovd = ovd;
    for (int d = 0; d < NDEV; d++) begin
      present[d] = (d < ndev);
      dev_act[d] = present[d];
      m_act[d] = present[d];
    end
    dev_bit = 0; m_bit = 0; sub_nx = 0; cur_sub = 0;
    slot_total = 0; max_low = 0; min_low = 1000;
    srch_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_data = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // dmode: 0 all hints 0, 1 all hints 1, 2 random
  task automatic run_search(input bit ovd, input int ndev, input int dmode, input int bp_byte,
                            output logic [63:0] id, output int disc_cnt);
    prepare(ovd, ndev);
    id = 64'h0;
    disc_cnt = 0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] dir, exp;
      dir = (dmode == 0) ? 8'h00 : (dmode == 1) ? 8'hFF : 8'($urandom);
      model_byte(dir, exp);
      send_byte(dir);
      while (!out_valid) @(negedge clk);
      // R4, R9: twelve slots, result only after the last one
      check(slot_total == 12 * (i + 1), "R9 slot count at result", 64'(slot_total), 64'(12 * (i + 1)));
      check(out_data == exp, "R5/R6/R7/R8 result byte", 64'(out_data), 64'(exp));
      if (i == bp_byte) begin
        logic [7:0] held;
        held = out_data;
        repeat (20) @(negedge clk);
        check(out_valid && out_data == held && !in_ready, "R3 back-pressure hold",
              {out_valid, in_ready, out_data}, {1'b1, 1'b0, held});
        check(!ow_pull, "R9 bus idle while result pending", 64'(ow_pull), 64'h0);
      end
      for (int k = 0; k < 4; k++) begin
        id[4*i+k] = out_data[2*k+1];
        disc_cnt += out_data[2*k];
      end
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    srch_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] id;
    int dc;
    bit hit;
    void'($urandom(32'h1A2B3C4D));
    for (int d = 0; d < NDEV; d++) begin
      rom[d] = {$urandom, $urandom};
      present[d] = 0; dev_act[d] = 0;
    end
    rom[0] = 64'hA5F0_3C00_1234_5608;
    rom[1] = 64'hA5F0_3C00_1234_5609 ^ 64'h0000_0100_0000_0000;

    repeat (5) @(negedge clk);
    // R1: reset state
    check(!out_valid && !ow_pull && !in_ready, "R1 reset state",
          {out_valid, ow_pull, in_ready}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid && !ow_pull && !in_ready, "R1 state after reset release",
          {out_valid, ow_pull, in_ready}, 64'h0);

    // R2: disabled mode ignores a host byte
    in_valid = 1'b1; in_data = 8'hAA;
    begin
      bit seen;
      seen = 0;
      for (int c = 0; c < 30; c++) begin
        @(negedge clk);
        if (ow_pull || in_ready || out_valid) seen = 1;
      end
      check(!seen, "R2 disabled block stays quiet", 64'(seen), 64'h0);
    end
    in_valid = 1'b0;

    // R5, R6: single device, hints all 0
    run_search(1'b0, 1, 0, 5, id, dc);
    check(id == rom[0], "R5 identifier rebuilt from one device", id, rom[0]);
    check(dc == 0, "R6 no discrepancy with one device", 64'(dc), 64'h0);
    check(max_low == NL0 && min_low == NL1, "R10 normal pulse widths",
          {32'(max_low), 32'(min_low)}, {32'(NL0), 32'(NL1)});

    // R7: two devices, hints 0 then hints 1
    run_search(1'b0, 2, 0, -1, id, dc);
    check(id == rom[0] || id == rom[1], "R7 zero-branch search finds a device", id, rom[0]);
    check(dc > 0, "R7 discrepancy flagged", 64'(dc), 64'h1);
    run_search(1'b0, 2, 1, -1, id, dc);
    check(id == rom[0] || id == rom[1], "R7 one-branch search finds a device", id, rom[1]);

    // R8: empty bus
    run_search(1'b0, 0, 2, -1, id, dc);
    check(id == 64'hFFFF_FFFF_FFFF_FFFF && dc == 64, "R8 empty bus all ones",
          id, 64'hFFFF_FFFF_FFFF_FFFF);

    // R10, R11: overdrive timing with random hints
    run_search(1'b1, 2, 2, 3, id, dc);
    check(max_low == OL0 && min_low == OL1, "R10 overdrive pulse widths",
          {32'(max_low), 32'(min_low)}, {32'(OL0), 32'(OL1)});

    // random populations and hints
    for (int r = 0; r < 2; r++) begin
      for (int d = 0; d < NDEV; d++) rom[d] = {$urandom, $urandom};
      run_search(1'b0, 2 + r + 1, 2, -1, id, dc);
      hit = 0;
      for (int d = 0; d < NDEV; d++) if (d < 3 + r && id == rom[d]) hit = 1;
      check(hit, "R4 random search lands on a device", id, rom[0]);
    end

    // R2: abort in the middle of a byte
    prepare(1'b0, 2);
    in_data = 8'h00; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (30) @(negedge clk);
    srch_en = 1'b0;
    repeat (2) @(negedge clk);
    check(!ow_pull && !out_valid && !in_ready, "R2 abort releases line",
          {ow_pull, out_valid, in_ready}, 64'h0);
    begin
      bit seen;
      seen = 0;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (ow_pull || out_valid) seen = 1;
      end
      check(!seen, "R2 no activity after abort", 64'(seen), 64'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule